// File: doc/BRIEF.md
# Programmable Serial CRC Engine

This block computes a cyclic redundancy check one bit at a time over a serial message that arrives most significant bit first. The code length (0 to 8 bits), the feedback polynomial and the starting value of the check register are runtime inputs. A start pulse reloads the register from the seed. After that, each strobed data bit is folded into the running remainder.

When the phase indicator switches from data to check bits, the engine acts according to its direction input. In transmit direction it presents the remainder on a serial output, most significant bit first, one bit per strobe. The check bits therefore follow straight after the last data bit. In receive direction it compares each incoming check bit against the matching remainder bit and raises a sticky error flag on any difference.

Message framing, bit timing and storage of received words belong to the surrounding logic.

Top module: `serial_crc_engine`

## Requirements
- R1: While reset is asserted, and directly after it, `crc_bit_o` and `crc_err_o` are 0.
- R2: A cycle with `start_i` high loads the check register with `cfg_seed_i` masked to the effective length. It also clears the error flag and the count of check bits consumed. A `bit_valid_i` strobe in the same cycle is ignored.
- R3: On a strobed bit with `crc_phase_i`=0, the feedback is the data bit XOR the register bit at index (length-1). The register shifts left by one, XORs in `cfg_poly_i` when the feedback is 1, and then clears all bits at or above the length. A length field above 8 acts as 8.
- R4: `cfg_poly_i` holds the polynomial coefficients of x^(len-1) down to x^0, with the top term implied. Under the standard setting (length 4, polynomial x^4+1 written as 0x01, seed 0xA), eight or sixteen zero data bits produce the check value 1010.
- R5: In transmit direction (`rx_mode_i`=0) with `crc_phase_i`=1, `crc_bit_o` shows register bit (length-1), and each strobe shifts the register left by one. The first n strobed check bits therefore carry the remainder MSB first. In every other situation `crc_bit_o` is 0.
- R6: In receive direction (`rx_mode_i`=1), a strobed check bit that differs from register bit (length-1) sets `crc_err_o` from the next cycle on. The flag stays set until the next start pulse.
- R7: Under the standard setting, an all-zero 8-bit reply whose check bits are 0000 is flagged, and one whose check bits are 1010 is not.
- R8: With a length of 0, `crc_bit_o` stays 0 and `crc_err_o` is never set.
- R9: Check-phase strobes after the first n (n = effective length) change neither the register nor the error flag.
- R10: Cycles without `start_i` or `bit_valid_i` leave the register, the count and the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Reload seed, clear error and check-bit count |
| bit_valid_i | input | 1 | Strobe: `bit_i` carries a message bit this cycle |
| bit_i | input | 1 | Serial message bit, MSB first |
| crc_phase_i | input | 1 | 0 = data bits, 1 = check bits |
| rx_mode_i | input | 1 | 0 = transmit direction, 1 = receive direction |
| cfg_len_i | input | 4 | Check length in bits (0 to 8; larger acts as 8) |
| cfg_poly_i | input | 8 | Polynomial coefficients below the implied top term |
| cfg_seed_i | input | 8 | Initial register value |
| crc_bit_o | output | 1 | Serial check bit in transmit direction |
| crc_err_o | output | 1 | Sticky receive mismatch flag |

## Verification
The bench targets the top-bit selection across lengths. A wrong index would still give the right answer at length 8 but wrong remainders at 4 or 1. It also checks that the length field is clamped, since a design that did not clamp would index outside the register at lengths 9 to 15. Surplus check strobes are sent after the n-th one: a design without a counter would compare them against shifted-in zeros and raise a false error. A start pulse is given together with a strobe, and a design that let the strobe through would corrupt the seed. Length 0 is run with garbage check bits, where a missing guard would flag errors on a code that has no bits.

// File: rtl/serial_crc_pkg.sv
package serial_crc_pkg;

    // Widest check register supported by the engine
    localparam int MAX_CRC_W   = 8;
    // Width of the length configuration field
    localparam int LEN_FIELD_W = 4;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } crc_dir_e;

endpackage

// File: rtl/serial_crc_cfg.sv
module serial_crc_cfg #(
    parameter int CRC_W = serial_crc_pkg::MAX_CRC_W,
    parameter int LEN_W = serial_crc_pkg::LEN_FIELD_W,
    localparam int IDX_W = (CRC_W > 1) ? $clog2(CRC_W) : 1
) (
    input  logic [LEN_W-1:0] cfg_len_i,
    output logic [LEN_W-1:0] len_eff_o,
    output logic [CRC_W-1:0] mask_o,
    output logic [IDX_W-1:0] top_idx_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(CRC_W);

    // Clamp oversize length requests to the register width (R3)
    always_comb begin
        if (cfg_len_i > LEN_MAX) begin
            len_eff_o = LEN_MAX;
        end else begin
            len_eff_o = cfg_len_i;
        end
    end

    // Index of the feedback / output bit; meaningless when length is 0
    assign top_idx_o = IDX_W'(len_eff_o - LEN_W'(1));

    // Bit i is kept only while i lies below the effective length
    for (genvar i = 0; i < CRC_W; i++) begin : g_mask
        assign mask_o[i] = (len_eff_o > LEN_W'(i));
    end

endmodule

// File: rtl/serial_crc_reg.sv
module serial_crc_reg #(
    parameter int CRC_W = serial_crc_pkg::MAX_CRC_W,
    localparam int IDX_W = (CRC_W > 1) ? $clog2(CRC_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             upd_data_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic [CRC_W-1:0] seed_i,
    input  logic [CRC_W-1:0] poly_i,
    input  logic [CRC_W-1:0] mask_i,
    input  logic [IDX_W-1:0] top_idx_i,
    output logic [CRC_W-1:0] crc_o,
    output logic             top_bit_o
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    fb;

    assign top_bit_o = st_q.crc[top_idx_i];
    assign crc_o     = st_q.crc;

    always_comb begin
        st_d = st_q;
        fb   = bit_i ^ top_bit_o;
        if (start_i) begin
            // Reload from the seed (R2)
            st_d.crc = seed_i & mask_i;
        end else if (upd_data_i) begin
            // Divide by the polynomial one bit at a time (R3)
            st_d.crc = ((st_q.crc << 1) ^ (fb ? poly_i : '0)) & mask_i;
        end else if (shift_i) begin
            // Move the next check bit into the output position (R5, R6)
            st_d.crc = (st_q.crc << 1) & mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Idle cycles leave the remainder untouched
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !upd_data_i && !shift_i) |=> $stable(crc_o));

    // A start pulse leaves no bit at or above the selected length
    assert_seed_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ((crc_o & ~$past(mask_i)) == '0));

endmodule

// File: rtl/serial_crc_check.sv
module serial_crc_check #(
    parameter int LEN_W = serial_crc_pkg::LEN_FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             slot_i,
    input  logic             rx_i,
    input  logic             bit_i,
    input  logic             top_bit_i,
    input  logic [LEN_W-1:0] len_eff_i,
    output logic             active_o,
    output logic             accept_o,
    output logic             err_o
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             err;
    } chk_st_t;

    chk_st_t st_d, st_q;

    // Check bits still owed while the count is below the length (R8, R9)
    assign active_o = (st_q.cnt < len_eff_i);
    assign accept_o = slot_i && active_o && !start_i;
    assign err_o    = st_q.err;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (accept_o) begin
            st_d.cnt = st_q.cnt + LEN_W'(1);
            if (rx_i && (bit_i != top_bit_i)) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!err_o && (st_q.cnt == '0)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    assert_err_only_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !(accept_o && rx_i)) |=> !err_o);

    assert_len_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_eff_i == '0) |-> !accept_o);

endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine #(
    parameter int CRC_W = serial_crc_pkg::MAX_CRC_W,
    parameter int LEN_W = serial_crc_pkg::LEN_FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic             crc_phase_i,
    input  logic             rx_mode_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic [CRC_W-1:0] cfg_poly_i,
    input  logic [CRC_W-1:0] cfg_seed_i,
    output logic             crc_bit_o,
    output logic             crc_err_o
);

    import serial_crc_pkg::*;

    localparam int IDX_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;

    logic [LEN_W-1:0] len_eff;
    logic [CRC_W-1:0] mask;
    logic [IDX_W-1:0] top_idx;
    logic [CRC_W-1:0] crc_val;
    logic             top_bit;
    logic             active;
    logic             accept;
    logic             upd_data;
    logic             is_rx;

    assign is_rx    = (crc_dir_e'(rx_mode_i) == DIR_RX);
    assign upd_data = bit_valid_i && !crc_phase_i && !start_i;

    serial_crc_cfg #(.CRC_W(CRC_W), .LEN_W(LEN_W)) i_cfg (
        .cfg_len_i (cfg_len_i),
        .len_eff_o (len_eff),
        .mask_o    (mask),
        .top_idx_o (top_idx)
    );

    serial_crc_reg #(.CRC_W(CRC_W)) i_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .upd_data_i (upd_data),
        .shift_i    (accept),
        .bit_i      (bit_i),
        .seed_i     (cfg_seed_i),
        .poly_i     (cfg_poly_i),
        .mask_i     (mask),
        .top_idx_i  (top_idx),
        .crc_o      (crc_val),
        .top_bit_o  (top_bit)
    );

    serial_crc_check #(.LEN_W(LEN_W)) i_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .slot_i    (bit_valid_i && crc_phase_i),
        .rx_i      (is_rx),
        .bit_i     (bit_i),
        .top_bit_i (top_bit),
        .len_eff_i (len_eff),
        .active_o  (active),
        .accept_o  (accept),
        .err_o     (crc_err_o)
    );

    // Serial check output only in transmit direction during the check window
    assign crc_bit_o = !is_rx && crc_phase_i && active && top_bit;

    assert_txbit_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_bit_o |-> (!rx_mode_i && crc_phase_i));

    assert_data_phase_keeps_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_phase_i && !start_i) |=> (crc_err_o == $past(crc_err_o)));

    assert_remainder_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((crc_val & ~mask) != '0) |-> $past(cfg_len_i) != cfg_len_i || $past(cfg_len_i, 2) != cfg_len_i);

endmodule

// File: tb/test_serial_crc_engine.sv
module test_serial_crc_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       phase = 1'b0;
    logic       rx = 1'b0;
    logic [3:0] cfg_len = 4'd4;
    logic [7:0] cfg_poly = 8'h01;
    logic [7:0] cfg_seed = 8'h0A;
    logic       crc_bit_o;
    logic       crc_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int m_crc = 0;
    int m_cnt = 0;
    int m_err = 0;
    logic [15:0] cap = '0;

    always #4 clk = ~clk;

    serial_crc_engine i_serial_crc_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .bit_valid_i (valid),
        .bit_i       (bit_in),
        .crc_phase_i (phase),
        .rx_mode_i   (rx),
        .cfg_len_i   (cfg_len),
        .cfg_poly_i  (cfg_poly),
        .cfg_seed_i  (cfg_seed),
        .crc_bit_o   (crc_bit_o),
        .crc_err_o   (crc_err_o)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int eff_len();
        return (int'(cfg_len) > 8) ? 8 : int'(cfg_len);
    endfunction

    // Behavioural remainder of a data word, MSB first
    function automatic int calc_crc(input int data, input int nd);
        int len = eff_len();
        int mask = (1 << len) - 1;
        int r = int'(cfg_seed) & mask;
        for (int i = nd - 1; i >= 0; i--) begin
            int top = (len > 0) ? ((r >> (len - 1)) & 1) : 0;
            int fb = ((data >> i) & 1) ^ top;
            r = ((r << 1) ^ (fb != 0 ? int'(cfg_poly) : 0)) & mask;
        end
        return r;
    endfunction

    // One clock: drive, compare against the model, advance the model
    task automatic step(input bit st, input bit v, input bit b, input bit ph, input string tag);
        int len, mask, top, act, exp_bit, fb;
        start = st; valid = v; bit_in = b; phase = ph;
        #1;
        len  = eff_len();
        mask = (1 << len) - 1;
        top  = (len > 0) ? ((m_crc >> (len - 1)) & 1) : 0;
        act  = (m_cnt < len) ? 1 : 0;
        exp_bit = (!rx && ph && act != 0) ? top : 0;
        check(tag, "crc_bit_o", int'(crc_bit_o), exp_bit);
        check(tag, "crc_err_o", int'(crc_err_o), m_err);
        if (ph && !rx && v && act != 0) cap = {cap[14:0], crc_bit_o};
        if (st) begin
            m_crc = int'(cfg_seed) & mask;
            m_cnt = 0;
            m_err = 0;
        end else if (v && !ph) begin
            fb = int'(b) ^ top;
            m_crc = ((m_crc << 1) ^ (fb != 0 ? int'(cfg_poly) : 0)) & mask;
        end else if (v && ph && act != 0) begin
            if (rx && (int'(b) != top)) m_err = 1;
            m_crc = (m_crc << 1) & mask;
            m_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic frame(input bit rx_m, input bit start_v, input int data, input int nd,
                         input int crcv, input int nc, input bit gap, input string tag);
        rx = rx_m;
        cap = '0;
        step(1'b1, start_v, 1'b1, 1'b0, tag);
        for (int i = nd - 1; i >= 0; i--) begin
            step(1'b0, 1'b1, 1'((data >> i) & 1), 1'b0, tag);
            if (gap) step(1'b0, 1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)), tag);
        end
        for (int i = 0; i < nc; i++) begin
            step(1'b0, 1'b1, 1'((crcv >> (nc - 1 - i)) & 1), 1'b1, tag);
            if (gap) step(1'b0, 1'b0, 1'($urandom_range(1)), 1'b1, tag);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int c;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", "crc_bit_o in reset", int'(crc_bit_o), 0);
        check("R1", "crc_err_o in reset", int'(crc_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "crc_bit_o after reset", int'(crc_bit_o), 0);
        check("R1", "crc_err_o after reset", int'(crc_err_o), 0);

        // R4 / R5: standard setting, zero data, transmit
        cfg_len = 4'd4; cfg_poly = 8'h01; cfg_seed = 8'h0A;
        frame(1'b0, 1'b0, 0, 8, 0, 4, 1'b0, "R5");
        check("R4", "tx check bits 8 zeros", int'(cap[3:0]), 4'b1010);
        frame(1'b0, 1'b0, 0, 16, 0, 4, 1'b0, "R5");
        check("R4", "tx check bits 16 zeros", int'(cap[3:0]), 4'b1010);

        // R7: receive all-zero replies
        frame(1'b1, 1'b0, 0, 8, 0, 4, 1'b0, "R7");
        check("R7", "zero reply with 0000 flagged", int'(crc_err_o), 1);
        frame(1'b1, 1'b0, 0, 8, 4'b1010, 4, 1'b0, "R7");
        check("R7", "zero reply with 1010 accepted", int'(crc_err_o), 0);

        // R6: sticky until start, cleared by start (R2)
        frame(1'b1, 1'b0, 8'h5C, 8, calc_crc(8'h5C, 8) ^ 1, 4, 1'b0, "R6");
        repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
        check("R6", "error held over idle", int'(crc_err_o), 1);
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        check("R2", "start clears error", int'(crc_err_o), 0);

        // R3: eight-bit code, correct and corrupted receive
        cfg_len = 4'd8; cfg_poly = 8'h07; cfg_seed = 8'hFF;
        c = calc_crc(16'hB3E1, 16);
        frame(1'b0, 1'b0, 16'hB3E1, 16, 0, 8, 1'b0, "R3");
        check("R3", "tx remainder len 8", int'(cap[7:0]), c);
        frame(1'b1, 1'b0, 16'hB3E1, 16, c, 8, 1'b0, "R3");
        check("R3", "rx good len 8", int'(crc_err_o), 0);
        frame(1'b1, 1'b0, 16'hB3E1, 16, c ^ 8'h10, 8, 1'b0, "R6");
        check("R6", "rx corrupted len 8", int'(crc_err_o), 1);

        // R3: clamp of oversize length field
        cfg_len = 4'd13;
        c = calc_crc(12'hA5F, 12);
        frame(1'b0, 1'b0, 12'hA5F, 12, 0, 8, 1'b0, "R3");
        check("R3", "clamped length tx remainder", int'(cap[7:0]), c);

        // R8: length 0
        cfg_len = 4'd0;
        frame(1'b1, 1'b0, 8'hFF, 8, 8'hFF, 8, 1'b0, "R8");
        check("R8", "no error at length 0", int'(crc_err_o), 0);

        // R9: surplus check strobes ignored
        cfg_len = 4'd4; cfg_poly = 8'h03; cfg_seed = 8'h00;
        c = calc_crc(10'h2C7, 10);
        frame(1'b1, 1'b0, 10'h2C7, 10, (c << 3) | 3'b101, 7, 1'b0, "R9");
        check("R9", "surplus strobes do not flag", int'(crc_err_o), 0);

        // R2: start with a simultaneous strobe; R10: gaps between strobes
        cfg_len = 4'd5; cfg_poly = 8'h05; cfg_seed = 8'h1F;
        c = calc_crc(9'h133, 9);
        frame(1'b1, 1'b1, 9'h133, 9, c, 5, 1'b1, "R10");
        check("R10", "gapped frame good", int'(crc_err_o), 0);
        frame(1'b0, 1'b1, 9'h133, 9, 0, 5, 1'b1, "R2");
        check("R2", "strobe during start ignored", int'(cap[4:0]), c);

        // Mixed settings against the model
        for (int k = 0; k < 60; k++) begin
            int nd, d, len;
            bit good;
            cfg_len  = 4'($urandom_range(15));
            cfg_poly = 8'($urandom);
            cfg_seed = 8'($urandom);
            nd = $urandom_range(16, 1);
            d  = int'($urandom) & ((1 << nd) - 1);
            len = eff_len();
            good = 1'($urandom_range(1));
            c = calc_crc(d, nd) ^ (good ? 0 : 1);
            frame(1'($urandom_range(1)), 1'($urandom_range(1)), d, nd, c,
                  len + $urandom_range(2), 1'($urandom_range(1)), "R3");
        end

        summary();
        $finish;
    end

endmodule